// File: doc/BRIEF.md
# Recirculating Serial Word Store

This block is a word store whose contents travel continuously through shift-register loops, one bit per clock, the way an acoustic delay line holds a pulse train. There are 32 loops, called tanks. Each tank carries 16 word slots. Every slot is 36 bit times long: 35 data bits followed by one idle gap bit. All tanks share a free-running bit counter and slot counter, so at any clock every tank presents the same bit of the same slot at its read point.

A requester raises `reqValid` together with an address, a write flag, a long/short flag and write data. It holds them until `reqAck` pulses. The block splits the address into a tank, a slot and a half select. It waits until the chosen slot starts to arrive at the read point. During the 36 bit times of that slot it then does one of two things:
- it shifts the word serially into a capture register, or
- it substitutes the new bits for the circulating ones.

Every other bit of every tank is written back unchanged.

Word layout is LSB first in time: the low half-word occupies bits 16..0, the joining digit bit 17, and the high half-word bits 34..18. A short access touches only one 17-bit half. The time an access takes depends on where the addressed slot sits in the train when the request is accepted.

Top module: `delay_store`

## Requirements
- R1: The 10-bit `reqAddr` is decoded as tank = bits 9..5, slot = bits 4..1 and half select = bit 0, giving 512 distinct words; half select matters only for short accesses.
- R2: A long write stores all 35 bits of `reqWdata`; a later long read returns that word on `rdData`.
- R3: A short write with half select 0 replaces word bits 16..0 with `reqWdata[16:0]`; with half select 1 it replaces bits 34..18 with `reqWdata[16:0]`. In both cases the other half and the joining digit (bit 17) are left as they were.
- R4: A short read returns the selected half right-justified in `rdData[16:0]`, with bits 34..17 zero.
- R5: Words that are not written keep their values indefinitely while circulating, in the same tank and in every other tank.
- R6: `reqAck` is a single-cycle pulse. Counting the acceptance edge as cycle 0, it is high in a cycle from 37 to 612 inclusive. The bit counter runs 0..35 and the slot counter 0..15, both free-running.
- R7: `rdData` changes only in the cycle `reqAck` is high after a read; a write leaves it unchanged.
- R8: After reset every word reads as zero, `reqAck` is low and `rdData` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present; held until `reqAck` |
| reqAddr | input | 10 | Tank, slot and half select |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqLong | input | 1 | 1 = 35-bit word, 0 = 17-bit half |
| reqWdata | input | 35 | Write data (short writes use bits 16..0) |
| reqAck | output | 1 | One-cycle completion pulse |
| rdData | output | 35 | Result of the most recent read |

## Verification
The bound checker watches, on every cycle, the timing skeleton of the store:
- the bit and slot counters step and wrap correctly;
- the acknowledge is a one-cycle pulse and falls inside the window set by slot position;
- the read register moves only when an acknowledge is present.

Whether the right bits come back is something only the bench's scenarios can show. That covers:
- address decoding across tank and slot boundaries;
- merging a half-word write around the untouched joining digit;
- words surviving many circulations beside accessed neighbours.

The bench checks these against its own word model through a scoreboard queue.

// File: rtl/delay_store_pkg.sv
package delay_store_pkg;
  localparam int NUM_TANKS = 32;
  localparam int SLOTS     = 16;
  localparam int SLOT_BITS = 36;
  localparam int HALF_BITS = 17;

  localparam int WORD_BITS = 2 * HALF_BITS + 1;
  localparam int TANK_LEN  = SLOTS * SLOT_BITS;
  localparam int TANK_W    = $clog2(NUM_TANKS);
  localparam int SLOT_W    = $clog2(SLOTS);
  localparam int BIT_W     = $clog2(SLOT_BITS);
  localparam int ADDR_W    = TANK_W + SLOT_W + 1;

  // Handshake latency window, counted from the acceptance edge.
  localparam int LAT_MIN   = SLOT_BITS + 1;
  localparam int LAT_MAX   = TANK_LEN + SLOT_BITS;

  typedef struct packed {
    logic              capture;  // request latched this edge
    logic              xfer;     // addressed slot at read point
    logic              writeOn;  // current access is a write
    logic              inField;  // current bit belongs to accessed field
    logic              finish;   // last bit time of addressed slot
    logic              isLong;
    logic              halfSel;
    logic [TANK_W-1:0] tank;
    logic [BIT_W-1:0]  bitIdx;
  } strobe_t;
endpackage

// File: rtl/delay_store_ctrl.sv
module delay_store_ctrl
  import delay_store_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqLong,
  output logic              reqAck,
  output strobe_t           stb,
  output logic [BIT_W-1:0]  bitCnt,
  output logic [SLOT_W-1:0] slotCnt
);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(SLOT_BITS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
  localparam logic [BIT_W-1:0]  WORD_END  = BIT_W'(WORD_BITS);
  localparam logic [BIT_W-1:0]  JOIN_IDX  = BIT_W'(HALF_BITS);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER, S_DONE} state_t;
  state_t state;

  logic [TANK_W-1:0] tgtTank;
  logic [SLOT_W-1:0] tgtSlot;
  logic              halfSel;
  logic              isLong;
  logic              isWrite;
  logic              slotHit;
  logic              inField;

  // Shared circulation timing for all tanks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      slotCnt <= '0;
    end else if (bitCnt == BIT_LAST) begin
      bitCnt  <= '0;
      slotCnt <= (slotCnt == SLOT_LAST) ? '0 : slotCnt + 1'b1;
    end else begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  assign slotHit = (slotCnt == tgtSlot) && (bitCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tgtTank <= '0;
      tgtSlot <= '0;
      halfSel <= 1'b0;
      isLong  <= 1'b0;
      isWrite <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (reqValid) begin
          tgtTank <= reqAddr[ADDR_W-1:SLOT_W+1];
          tgtSlot <= reqAddr[SLOT_W:1];
          halfSel <= reqAddr[0];
          isLong  <= reqLong;
          isWrite <= reqWrite;
          state   <= S_WAIT;
        end
        S_WAIT: if (slotHit) state <= S_XFER;
        S_XFER: if (bitCnt == BIT_LAST) state <= S_DONE;
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    if (isLong)       inField = bitCnt < WORD_END;
    else if (halfSel) inField = (bitCnt > JOIN_IDX) && (bitCnt < WORD_END);
    else              inField = bitCnt < JOIN_IDX;
  end

  assign reqAck      = (state == S_DONE);
  assign stb.capture = (state == S_IDLE) && reqValid;
  assign stb.xfer    = ((state == S_WAIT) && slotHit) || (state == S_XFER);
  assign stb.writeOn = isWrite;
  assign stb.inField = inField;
  assign stb.finish  = (state == S_XFER) && (bitCnt == BIT_LAST);
  assign stb.isLong  = isLong;
  assign stb.halfSel = halfSel;
  assign stb.tank    = tgtTank;
  assign stb.bitIdx  = bitCnt;
endmodule

// File: rtl/delay_store_dp.sv
module delay_store_dp
  import delay_store_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [WORD_BITS-1:0] reqWdata,
  output logic [WORD_BITS-1:0] rdData
);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(SLOT_BITS - 1);
  localparam logic [BIT_W-1:0] WORD_END  = BIT_W'(WORD_BITS);
  localparam logic [BIT_W-1:0] HIGH_BASE = BIT_W'(HALF_BITS + 1);

  logic [NUM_TANKS-1:0] taps;
  logic [WORD_BITS-1:0] wdLatch;
  logic [WORD_BITS-1:0] capWord;
  logic [BIT_W-1:0]     srcIdx;
  logic                 wrBit;
  logic                 gapBit;
  logic                 tapSel;

  assign gapBit = (stb.bitIdx == BIT_LAST);
  assign srcIdx = (!stb.isLong && stb.halfSel) ? stb.bitIdx - HIGH_BASE : stb.bitIdx;
  assign wrBit  = wdLatch[srcIdx];
  assign tapSel = taps[stb.tank];

  // One recirculating loop per tank; read point is bit 0
  for (genvar t = 0; t < NUM_TANKS; t++) begin : g_tank
    logic [TANK_LEN-1:0] line;
    logic                nextBit;

    always_comb begin
      if (gapBit)
        nextBit = 1'b0;
      else if (stb.xfer && stb.writeOn && stb.inField && (stb.tank == TANK_W'(t)))
        nextBit = wrBit;
      else
        nextBit = line[0];
    end

    always_ff @(posedge clk) begin
      if (!rstN) line <= '0;
      else       line <= {nextBit, line[TANK_LEN-1:1]};
    end

    assign taps[t] = line[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdLatch <= '0;
      capWord <= '0;
      rdData  <= '0;
    end else begin
      if (stb.capture) wdLatch <= reqWdata;
      if (stb.xfer && (stb.bitIdx < WORD_END)) capWord[stb.bitIdx] <= tapSel;
      if (stb.finish && !stb.writeOn) begin
        if (stb.isLong)       rdData <= capWord;
        else if (stb.halfSel) rdData <= WORD_BITS'(capWord[WORD_BITS-1:HALF_BITS+1]);
        else                  rdData <= WORD_BITS'(capWord[HALF_BITS-1:0]);
      end
    end
  end
endmodule

// File: rtl/delay_store.sv
module delay_store
  import delay_store_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 reqWrite,
  input  logic                 reqLong,
  input  logic [WORD_BITS-1:0] reqWdata,
  output logic                 reqAck,
  output logic [WORD_BITS-1:0] rdData
);
  strobe_t           stb;
  logic [BIT_W-1:0]  bitCnt;
  logic [SLOT_W-1:0] slotCnt;

  delay_store_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .reqLong  (reqLong),
    .reqAck   (reqAck),
    .stb      (stb),
    .bitCnt   (bitCnt),
    .slotCnt  (slotCnt)
  );

  delay_store_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqWdata (reqWdata),
    .rdData   (rdData)
  );
endmodule

// File: rtl/delay_store_chk.sv
module delay_store_chk
  import delay_store_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqAck,
  input logic                 capture,
  input logic [WORD_BITS-1:0] rdData,
  input logic [BIT_W-1:0]     bitCnt,
  input logic [SLOT_W-1:0]    slotCnt
);
  localparam int LW = $clog2(LAT_MAX + 2);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(SLOT_BITS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
  localparam logic [LW-1:0]     L_MIN     = LW'(LAT_MIN);
  localparam logic [LW-1:0]     L_MAX     = LW'(LAT_MAX);

  logic [LW-1:0] latCnt;

  always_ff @(posedge clk) begin
    if (!rstN)             latCnt <= '0;
    else if (reqAck)       latCnt <= '0;
    else if (capture)      latCnt <= LW'(1);
    else if (latCnt != '0) latCnt <= latCnt + 1'b1;
  end

  p_ack_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  p_ack_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> (latCnt >= L_MIN) && (latCnt <= L_MAX));

  p_bit_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt == BIT_LAST) |=> (bitCnt == '0));

  p_bit_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt != BIT_LAST) |=> (bitCnt == $past(bitCnt) + 1'b1) && $stable(slotCnt));

  p_slot_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt == BIT_LAST) |=>
      (slotCnt == (($past(slotCnt) == SLOT_LAST) ? '0 : $past(slotCnt) + 1'b1)));

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> reqAck);
endmodule

bind delay_store delay_store_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqAck  (reqAck),
  .capture (stb.capture),
  .rdData  (rdData),
  .bitCnt  (bitCnt),
  .slotCnt (slotCnt)
);

// File: tb/delay_store_test.sv
module delay_store_test;
  import delay_store_pkg::*;

  localparam int WORDS = NUM_TANKS * SLOTS;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 reqValid = 1'b0;
  logic [ADDR_W-1:0]    reqAddr = '0;
  logic                 reqWrite = 1'b0;
  logic                 reqLong = 1'b0;
  logic [WORD_BITS-1:0] reqWdata = '0;
  logic                 reqAck;
  logic [WORD_BITS-1:0] rdData;

  always #4 clk = ~clk;   // 125 MHz

  delay_store uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqLong(reqLong), .reqWdata(reqWdata),
    .reqAck(reqAck), .rdData(rdData)
  );

  typedef struct {
    logic [WORD_BITS-1:0] exp;
    string                tag;
  } item_t;

  item_t                sbq[$];
  logic [WORD_BITS-1:0] model [WORDS];
  logic [WORD_BITS-1:0] lastRd = '0;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // Driver: computes expected result from the model, queues it, runs handshake
  task automatic access(input int word, input bit half, input bit wr, input bit lng,
                        input logic [WORD_BITS-1:0] wd, input string tag);
    item_t it;
    int    lat;
    if (wr) begin
      if (lng)       model[word] = wd;
      else if (half) model[word][WORD_BITS-1:HALF_BITS+1] = wd[HALF_BITS-1:0];
      else           model[word][HALF_BITS-1:0] = wd[HALF_BITS-1:0];
      it.exp = lastRd;
    end else begin
      if (lng)       it.exp = model[word];
      else if (half) it.exp = WORD_BITS'(model[word][WORD_BITS-1:HALF_BITS+1]);
      else           it.exp = WORD_BITS'(model[word][HALF_BITS-1:0]);
      lastRd = it.exp;
    end
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    reqAddr  = {word[ADDR_W-2:0], half};
    reqWrite = wr;
    reqLong  = lng;
    reqWdata = wd;
    reqValid = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!reqAck);
    reqValid = 1'b0;
    check(lat >= LAT_MIN && lat <= LAT_MAX, "R6 latency window", 64'(lat), 64'(LAT_MIN));
    @(negedge clk);
    check(!reqAck, "R6 ack single pulse", 64'(reqAck), 64'(0));
  endtask

  // Monitor: pops one expectation per acknowledge
  always @(negedge clk) begin
    if (rstN && reqAck) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R6 unexpected ack", 64'(1), 64'(0));
      end else begin
        item_t it;
        it = sbq.pop_front();
        check(rdData === it.exp, it.tag, 64'(rdData), 64'(it.exp));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 64'(0), 64'(1));
      summary();
    end
  end

  initial begin
    int unsigned lcg;
    int          w;
    logic [WORD_BITS-1:0] v;
    for (int i = 0; i < WORDS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check(reqAck == 1'b0, "R8 ack low in reset", 64'(reqAck), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    check(rdData == '0, "R8 rdData zero after reset", 64'(rdData), 64'(0));
    check(reqAck == 1'b0, "R8 ack low after reset", 64'(reqAck), 64'(0));

    access(100, 0, 0, 1, '0, "R8 word zero after reset");
    access(511, 1, 0, 0, '0, "R8 half zero after reset");

    // Long writes at tank/slot boundaries
    access(0,   0, 1, 1, 35'h4_1234_5678, "R2 write w0");
    access(511, 0, 1, 1, 35'h7_FFFF_FFFE, "R2 write w511");
    access(16,  0, 1, 1, 35'h2_AAAA_5555, "R1 write tank1 slot0");
    access(15,  0, 1, 1, 35'h1_0F0F_F0F0, "R1 write tank0 slot15");
    access(17,  0, 1, 1, 35'h0_0002_0000, "R2 write w17 join bit set");
    access(0,   0, 0, 1, '0, "R2 read w0");
    access(511, 0, 0, 1, '0, "R2 read w511");
    access(16,  0, 0, 1, '0, "R1 read tank1 slot0");
    access(15,  0, 0, 1, '0, "R1 read tank0 slot15");

    // Half-word merges around the joining digit
    access(17,  0, 1, 0, 35'h0_0001_ABCD, "R3 short write low w17");
    access(17,  1, 1, 0, 35'h0_0000_F0F1, "R3 short write high w17");
    access(17,  0, 0, 1, '0, "R3 merged word w17");
    access(511, 0, 0, 0, '0, "R4 short read low w511");
    access(511, 1, 0, 0, '0, "R4 short read high w511");
    access(16,  1, 0, 0, '0, "R4 short read high w16");

    // Retention after much circulation
    access(0,   0, 0, 1, '0, "R5 retain w0");
    access(15,  0, 0, 1, '0, "R5 retain w15");
    access(1,   0, 0, 1, '0, "R5 untouched neighbour w1");

    // Pseudo-random long and short traffic, checked against the model
    lcg = 32'h1234_5678;
    for (int k = 0; k < 10; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      w = int'(lcg[24:16]);
      v = {lcg[2:0], lcg ^ 32'hA5A5_3C3C};
      access(w, lcg[5], 1, lcg[4], v, "R5 random write");
      access((w + 37) % WORDS, 0, 0, 1, '0, "R5 random other word");
      access(w, lcg[6], 0, lcg[7], '0, "R3 random readback");
    end
    access(17, 0, 0, 1, '0, "R5 final w17");

    repeat (4) @(negedge clk);
    check(sbq.size() == 0, "R6 all acks seen", 64'(sbq.size()), 64'(0));
    done = 1;
    summary();
  end
endmodule